// File: doc/BRIEF.md
# Oldest-First Stage Arbiter for a Chained Switch Column

One of these arbiters sits at each output port of each chip in a vertical chain of switch chips. All the chips in a column share one output line. Each stage holds two queues. The local queue takes cells from this chip's own switching fabric. The transit queue takes cells handed down by the stage directly above. Once per cell slot the stage picks at most one head cell and sends it downward, either into the transit queue of the stage below or, at the bottom stage, onto the output line. Arbitration only ever involves two adjacent stages, so the decision time does not grow with the length of the chain.

A cell entering the local queue is stamped with the value of a free-running timestamp counter. When both queues hold a cell, the older stamp wins, and the comparison allows for counter wraparound. When the stamps are equal, a small cyclic counter settles the tie. That counter is sized by the stage's position in the chain, so the local queue of stage k wins one tie in k. Flow control runs upward as a not-acknowledge level: a stage whose transit queue is close to full raises it, and the stage above holds its cell for that slot.

Top module: `cell_age_arbiter`

## Requirements
- R1: Synchronous reset empties both queues and clears the slot counter, the timestamp, the tie counter, `dn_valid` and `up_nack`. The first slot starts on the first clock after reset is released.
- R2: A slot lasts `SLOT_CYC` clocks, and a decision is taken only on the slot's first clock. If either queue holds a cell at that clock and `dn_nack` is low, `dn_valid` is high for exactly one clock on the next cycle, carrying the chosen cell's stamp on `dn_ts` and its payload on `dn_data`. A cell that arrives on the decision clock itself is not visible to that decision.
- R3: If `dn_nack` is high on a decision clock, no cell is sent, no queue is popped and the tie counter does not advance.
- R4: If only one queue holds a cell, that queue's head is sent. Each queue is strictly first-in first-out.
- R5: When both heads hold cells with different stamps a and b, and |a−b| < 2^(TS_W−1), the numerically smaller stamp is sent. When |a−b| ≥ 2^(TS_W−1), the numerically larger stamp is sent.
- R6: When both head stamps are equal, a tie counter decides. It counts 0,1,…,STAGE_K−1 and wraps, and it advances only on such ties when a cell is actually sent. A count of 0 sends the local head; any other count sends the transit head.
- R7: The timestamp starts at 0 and advances by one (modulo 2^TS_W) at the end of every `TS_PERIOD`-th slot. A local cell carries the timestamp value it saw on the clock it was accepted.
- R8: `up_nack` is registered and high exactly when the transit queue, after this clock's push and pop, has fewer than two free entries out of `TQ_DEPTH`. A transit cell offered while the queue is full is dropped.
- R9: With `STAGE_K` = 1 there is no transit queue: `up_valid`, `up_ts` and `up_data` have no effect and `up_nack` stays low.
- R10: A local cell offered while the local queue holds `LQ_DEPTH` cells is discarded. Cells already queued are sent unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loc_valid | input | 1 | A local cell is offered this clock |
| loc_data | input | PAY_W | Payload of the local cell |
| up_valid | input | 1 | A cell from the stage above is offered this clock |
| up_ts | input | TS_W | Stamp of the cell from above |
| up_data | input | PAY_W | Payload of the cell from above |
| up_nack | output | 1 | Transit queue nearly full; the stage above must hold |
| dn_nack | input | 1 | The stage below cannot take a cell this slot |
| dn_valid | output | 1 | One-clock pulse for a cell sent downward |
| dn_ts | output | TS_W | Stamp of the cell sent |
| dn_data | output | PAY_W | Payload of the cell sent |

## Verification
Two things can land on the same decision clock: a stamp tie that would advance the tie counter, and a held `dn_nack` that vetoes the slot. The bench loads both queues with equal-stamp pairs and then raises `dn_nack` across several slot boundaries. After release, the reference model expects the tie sequence to resume at the count where it stopped, not past it. A second collision, a transit push and a transit pop on the same clock, is provoked while the queue sits one entry below the threshold, and `up_nack` is judged against the model's queue occupancy on every clock.

// File: rtl/cell_arb_pkg.sv
package cell_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_LOCAL   = 2'd1,
    SRC_TRANSIT = 2'd2
  } src_e;

endpackage

// File: rtl/cell_fifo.sv
module cell_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R10: a push into a full queue without a pop leaves occupancy unchanged
  a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/cell_slot_timer.sv
module cell_slot_timer #(
  parameter int SLOT_CYC  = 8,
  parameter int TS_PERIOD = 1,
  parameter int TS_W      = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic            slot_start,
  output logic [TS_W-1:0] ts_now
);

  localparam int SW = (SLOT_CYC  > 1) ? $clog2(SLOT_CYC)  : 1;
  localparam int PW = (TS_PERIOD > 1) ? $clog2(TS_PERIOD) : 1;

  logic [SW-1:0] slot_cnt;
  logic [PW-1:0] per_cnt;

  assign slot_start = (slot_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      per_cnt  <= '0;
      ts_now   <= '0;
    end else if (slot_cnt == SW'(SLOT_CYC-1)) begin
      slot_cnt <= '0;
      if (per_cnt == PW'(TS_PERIOD-1)) begin
        per_cnt <= '0;
        ts_now  <= ts_now + 1'b1;
      end else begin
        per_cnt <= per_cnt + 1'b1;
      end
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  // R7: the timestamp only ever steps forward by one
  a_r7_ts_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(ts_now) |-> (ts_now == $past(ts_now) + 1'b1));

  // R7: the timestamp only moves right after a slot boundary
  a_r7_ts_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(ts_now) |-> slot_start);

endmodule

// File: rtl/cell_age_pick.sv
module cell_age_pick
  import cell_arb_pkg::*;
#(
  parameter int TS_W    = 8,
  parameter int STAGE_K = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lreq,
  input  logic            treq,
  input  logic [TS_W-1:0] lts,
  input  logic [TS_W-1:0] tts,
  input  logic            go,
  output src_e            pick
);

  localparam int TW = (STAGE_K > 1) ? $clog2(STAGE_K) : 1;
  localparam logic [TS_W-1:0] HALF = {1'b1, {(TS_W-1){1'b0}}};

  logic [TW-1:0]   tie_cnt;
  logic [TS_W-1:0] d_tl, d_lt;
  logic            l_older, t_older, ts_tie, tie_fire;

  assign d_tl   = tts - lts;
  assign d_lt   = lts - tts;
  assign ts_tie = (lts == tts);

  always_comb begin
    l_older = 1'b0;
    t_older = 1'b0;
    if (lts < tts) begin
      l_older = (d_tl < HALF);
      t_older = !l_older;
    end else if (lts > tts) begin
      t_older = (d_lt < HALF);
      l_older = !t_older;
    end
  end

  always_comb begin
    pick = SRC_NONE;
    if (lreq && !treq)      pick = SRC_LOCAL;
    else if (!lreq && treq) pick = SRC_TRANSIT;
    else if (lreq && treq) begin
      if (l_older)               pick = SRC_LOCAL;
      else if (t_older)          pick = SRC_TRANSIT;
      else if (tie_cnt == '0)    pick = SRC_LOCAL;
      else                       pick = SRC_TRANSIT;
    end
  end

  assign tie_fire = go && lreq && treq && ts_tie;

  always_ff @(posedge clk) begin
    if (rst) begin
      tie_cnt <= '0;
    end else if (tie_fire) begin
      tie_cnt <= (tie_cnt == TW'(STAGE_K-1)) ? '0 : tie_cnt + 1'b1;
    end
  end

  // R6: the tie counter stays within 0..STAGE_K-1
  a_r6_tie_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    tie_cnt <= TW'(STAGE_K-1));

  // R6: the tie counter holds unless a tie was resolved
  a_r6_tie_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !tie_fire |=> $stable(tie_cnt));

endmodule

// File: rtl/cell_age_arbiter.sv
module cell_age_arbiter
  import cell_arb_pkg::*;
#(
  parameter int STAGE_K   = 2,
  parameter int TS_W      = 8,
  parameter int TS_PERIOD = 1,
  parameter int SLOT_CYC  = 8,
  parameter int LQ_DEPTH  = 128,
  parameter int TQ_DEPTH  = 16,
  parameter int PAY_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loc_valid,
  input  logic [PAY_W-1:0] loc_data,
  input  logic             up_valid,
  input  logic [TS_W-1:0]  up_ts,
  input  logic [PAY_W-1:0] up_data,
  output logic             up_nack,
  input  logic             dn_nack,
  output logic             dn_valid,
  output logic [TS_W-1:0]  dn_ts,
  output logic [PAY_W-1:0] dn_data
);

  localparam int CELL_W = TS_W + PAY_W;
  localparam int LCW    = $clog2(LQ_DEPTH+1);
  localparam int TCW    = $clog2(TQ_DEPTH+1);

  logic              slot_start;
  logic [TS_W-1:0]   ts_now;
  logic [CELL_W-1:0] lq_head, tq_head;
  logic              lq_empty, tq_empty, tq_full;
  logic              lq_full_unused;
  logic [LCW-1:0]    lq_cnt_unused;
  logic [TCW-1:0]    tq_cnt, tq_cnt_nxt;
  logic              go, pop_l, pop_t, t_push;
  src_e              pick;

  cell_slot_timer #(
    .SLOT_CYC (SLOT_CYC),
    .TS_PERIOD(TS_PERIOD),
    .TS_W     (TS_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .slot_start(slot_start),
    .ts_now    (ts_now)
  );

  cell_fifo #(
    .DEPTH(LQ_DEPTH),
    .W    (CELL_W)
  ) u_local_q (
    .clk  (clk),
    .rst  (rst),
    .push (loc_valid),
    .wdata({ts_now, loc_data}),
    .pop  (pop_l),
    .rdata(lq_head),
    .empty(lq_empty),
    .full (lq_full_unused),
    .cnt  (lq_cnt_unused)
  );

  generate
    if (STAGE_K > 1) begin : g_transit
      cell_fifo #(
        .DEPTH(TQ_DEPTH),
        .W    (CELL_W)
      ) u_transit_q (
        .clk  (clk),
        .rst  (rst),
        .push (up_valid),
        .wdata({up_ts, up_data}),
        .pop  (pop_t),
        .rdata(tq_head),
        .empty(tq_empty),
        .full (tq_full),
        .cnt  (tq_cnt)
      );
      assign t_push = up_valid && !tq_full;
    end else begin : g_top_stage
      logic unused_up;
      assign unused_up = ^{up_valid, up_ts, up_data};
      assign tq_head   = '0;
      assign tq_empty  = 1'b1;
      assign tq_full   = 1'b0;
      assign tq_cnt    = '0;
      assign t_push    = 1'b0;
    end
  endgenerate

  assign go = slot_start && !dn_nack;

  cell_age_pick #(
    .TS_W   (TS_W),
    .STAGE_K(STAGE_K)
  ) u_pick (
    .clk (clk),
    .rst (rst),
    .lreq(!lq_empty),
    .treq(!tq_empty),
    .lts (lq_head[CELL_W-1 -: TS_W]),
    .tts (tq_head[CELL_W-1 -: TS_W]),
    .go  (go),
    .pick(pick)
  );

  assign pop_l      = go && (pick == SRC_LOCAL);
  assign pop_t      = go && (pick == SRC_TRANSIT);
  assign tq_cnt_nxt = tq_cnt + TCW'(t_push) - TCW'(pop_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_ts    <= '0;
      dn_data  <= '0;
      up_nack  <= 1'b0;
    end else begin
      dn_valid <= pop_l || pop_t;
      if (pop_l) {dn_ts, dn_data} <= lq_head;
      else if (pop_t) {dn_ts, dn_data} <= tq_head;
      up_nack <= (STAGE_K > 1) && ((TCW'(TQ_DEPTH) - tq_cnt_nxt) < TCW'(2));
    end
  end

  // R2: a cell leaves only right after a slot's first clock
  a_r2_send_on_slot: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> $past(slot_start));

  // R3: backpressure from below vetoes the slot
  a_r3_nack_blocks: assert property (@(posedge clk) disable iff (rst)
    (slot_start && dn_nack) |=> !dn_valid);

  // R8: the upward nack follows transit occupancy
  a_r8_nack_level: assert property (@(posedge clk) disable iff (rst)
    (STAGE_K > 1) |-> (up_nack == (tq_cnt >= TCW'(TQ_DEPTH-1))));

  // R9: the top stage never pushes back
  a_r9_top_quiet: assert property (@(posedge clk) disable iff (rst)
    (STAGE_K == 1) |-> !up_nack);

endmodule

// File: tb/test_cell_age_arbiter.sv
module test_cell_age_arbiter;

  localparam int K    = 3;
  localparam int TSW  = 4;
  localparam int TP   = 2;
  localparam int SC   = 8;
  localparam int LQD  = 16;
  localparam int TQD  = 16;
  localparam int PW   = 16;
  localparam int HALF = 8;
  localparam int TMOD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          loc_valid = 1'b0, up_valid = 1'b0, dn_nack = 1'b0;
  logic [PW-1:0] loc_data = '0, up_data = '0;
  logic [TSW-1:0] up_ts = '0;
  logic          up_nack, dn_valid;
  logic [TSW-1:0] dn_ts;
  logic [PW-1:0] dn_data;

  logic          s1_loc_valid = 1'b0, s1_up_valid = 1'b0;
  logic [PW-1:0] s1_up_data = '0;
  logic [TSW-1:0] s1_up_ts = '0;
  logic          s1_up_nack, s1_dn_valid;
  logic [TSW-1:0] s1_dn_ts;
  logic [PW-1:0] s1_dn_data;

  cell_age_arbiter #(.STAGE_K(K), .TS_W(TSW), .TS_PERIOD(TP), .SLOT_CYC(SC),
                     .LQ_DEPTH(LQD), .TQ_DEPTH(TQD), .PAY_W(PW)) i_cell_age_arbiter (
    .clk(clk), .rst(rst), .loc_valid(loc_valid), .loc_data(loc_data),
    .up_valid(up_valid), .up_ts(up_ts), .up_data(up_data), .up_nack(up_nack),
    .dn_nack(dn_nack), .dn_valid(dn_valid), .dn_ts(dn_ts), .dn_data(dn_data));

  cell_age_arbiter #(.STAGE_K(1), .TS_W(TSW), .TS_PERIOD(TP), .SLOT_CYC(SC),
                     .LQ_DEPTH(LQD), .TQ_DEPTH(TQD), .PAY_W(PW)) i_cell_age_arbiter_s1 (
    .clk(clk), .rst(rst), .loc_valid(s1_loc_valid), .loc_data('0),
    .up_valid(s1_up_valid), .up_ts(s1_up_ts), .up_data(s1_up_data), .up_nack(s1_up_nack),
    .dn_nack(1'b0), .dn_valid(s1_dn_valid), .dn_ts(s1_dn_ts), .dn_data(s1_dn_data));

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  // behavioural reference
  int lq_ts[$], lq_d[$], tq_ts[$], tq_d[$];
  int m_slot = 0, m_per = 0, m_ts = 0, m_tie = 0;
  bit exp_dv = 1'b0, exp_nack = 1'b0;
  int exp_ts = 0, exp_d = 0;
  bit m_lfull, m_tfull, m_lr, m_tr, m_takel;

  function automatic bit older(int a, int b);
    if (a < b) return (b - a) < HALF;
    if (a > b) return (a - b) >= HALF;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lq_ts.delete(); lq_d.delete(); tq_ts.delete(); tq_d.delete();
      m_slot = 0; m_per = 0; m_ts = 0; m_tie = 0;
      exp_dv = 1'b0; exp_nack = 1'b0;
    end else begin
      m_lfull = lq_ts.size() >= LQD;
      m_tfull = tq_ts.size() >= TQD;
      m_lr = lq_ts.size() > 0;
      m_tr = tq_ts.size() > 0;
      exp_dv = 1'b0;
      if (m_slot == 0 && !dn_nack && (m_lr || m_tr)) begin
        if (m_lr && !m_tr) m_takel = 1'b1;
        else if (!m_lr && m_tr) m_takel = 1'b0;
        else if (older(lq_ts[0], tq_ts[0])) m_takel = 1'b1;
        else if (older(tq_ts[0], lq_ts[0])) m_takel = 1'b0;
        else begin
          m_takel = (m_tie == 0);
          m_tie = (m_tie + 1) % K;
        end
        if (m_takel) begin
          exp_ts = lq_ts.pop_front(); exp_d = lq_d.pop_front();
        end else begin
          exp_ts = tq_ts.pop_front(); exp_d = tq_d.pop_front();
        end
        exp_dv = 1'b1;
      end
      if (loc_valid && !m_lfull) begin lq_ts.push_back(m_ts); lq_d.push_back(int'(loc_data)); end
      if (up_valid && !m_tfull) begin tq_ts.push_back(int'(up_ts)); tq_d.push_back(int'(up_data)); end
      exp_nack = (TQD - tq_ts.size()) < 2;
      if (m_slot == SC - 1) begin
        m_slot = 0;
        if (m_per == TP - 1) begin m_per = 0; m_ts = (m_ts + 1) % TMOD; end
        else m_per = m_per + 1;
      end else m_slot = m_slot + 1;
    end
  end

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(cur_req, "dn_valid", int'(dn_valid), int'(exp_dv));
      if (exp_dv) begin
        check(cur_req, "dn_ts", int'(dn_ts), exp_ts);
        check(cur_req, "dn_data", int'(dn_data), exp_d);
      end
      check(cur_req, "up_nack", int'(up_nack), int'(exp_nack));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_pair(int off, int d);
    loc_valid = 1'b1; loc_data = PW'(d);
    up_valid = 1'b1; up_ts = TSW'((m_ts + off) % TMOD); up_data = PW'(d + 1000);
    tick();
    loc_valid = 1'b0; up_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1: outputs idle after reset
    check("R1", "dn_valid after reset", int'(dn_valid), 0);
    check("R1", "up_nack after reset", int'(up_nack), 0);
    check("R1", "s1 up_nack after reset", int'(s1_up_nack), 0);
    cmp_on = 1'b1;

    // R9: stage 1 ignores transit input entirely
    for (int i = 0; i < 24; i++) begin
      s1_up_valid = 1'b1; s1_up_ts = TSW'(i); s1_up_data = PW'(i);
      tick();
      check("R9", "s1 up_nack", int'(s1_up_nack), 0);
      check("R9", "s1 dn_valid", int'(s1_dn_valid), 0);
    end
    s1_up_valid = 1'b0;
    tick(20);
    check("R9", "s1 dn_valid idle", int'(s1_dn_valid), 0);

    // R4: local only, in order
    cur_req = "R4";
    for (int i = 0; i < 3; i++) begin
      loc_valid = 1'b1; loc_data = PW'(10 + i); tick();
    end
    loc_valid = 1'b0;
    tick(40);
    // R4: transit only, in order
    for (int i = 0; i < 3; i++) begin
      up_valid = 1'b1; up_ts = TSW'(3 * i); up_data = PW'(20 + i); tick();
    end
    up_valid = 1'b0;
    tick(40);

    // R2: arrival in the middle of a slot waits for the next boundary
    cur_req = "R2";
    tick(3);
    loc_valid = 1'b1; loc_data = PW'(77); tick();
    loc_valid = 1'b0;
    tick(24);

    // R5: wraparound-aware age comparison
    cur_req = "R5";
    begin
      int offs[8] = '{3, 13, 8, 9, 7, 15, 1, 12};
      foreach (offs[j]) begin
        push_pair(offs[j], 100 + j);
        tick(24);
      end
    end

    // R6: ties follow the 1-in-K local share
    cur_req = "R6";
    for (int i = 0; i < 4; i++) push_pair(0, 200 + i);
    tick(80);

    // R3: nack from below on tie slots; counter must not advance
    cur_req = "R3";
    dn_nack = 1'b1;
    for (int i = 0; i < 2; i++) push_pair(0, 300 + i);
    tick(30);
    dn_nack = 1'b0;
    tick(50);

    // R8: fill transit queue, push and pop collide near the threshold
    cur_req = "R8";
    dn_nack = 1'b1;
    for (int i = 0; i < 18; i++) begin
      up_valid = 1'b1; up_ts = TSW'(m_ts); up_data = PW'(400 + i); tick();
    end
    dn_nack = 1'b0;
    for (int i = 0; i < 20; i++) begin
      up_valid = (i % 8 == 7); up_ts = TSW'(m_ts); up_data = PW'(450 + i); tick();
    end
    up_valid = 1'b0;
    tick(8 * 20);

    // R10: local overflow drops the extra cells
    cur_req = "R10";
    dn_nack = 1'b1;
    for (int i = 0; i < 20; i++) begin
      loc_valid = 1'b1; loc_data = PW'(500 + i); tick();
    end
    loc_valid = 1'b0;
    tick(4);
    dn_nack = 1'b0;
    tick(8 * 18);

    // R7: stamps across timestamp wrap
    cur_req = "R7";
    for (int i = 0; i < 36; i++) begin
      loc_valid = 1'b1; loc_data = PW'(600 + i); tick();
      loc_valid = 1'b0; tick(7);
    end
    tick(24);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule